// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block decides how a small processor core sleeps, idles and picks its clock. A single-cycle halt strobe moves the core from running into one of three halted modes. Two control bits choose the mode, and each mode gates its own set of clocks: deep sleep, idle with only the time-base clock running, or idle with every clock running and just the core held. A wake event returns the core to running on the next clock edge.

Every accepted halt clears an internal watchdog counter, which then restarts. The same halt sets a sticky power-down flag and clears the watchdog time-out flag. The watchdog keeps counting whenever it is enabled, in halted modes as well. When it passes its terminal count it wraps and raises the time-out flag.

While running, the block also chooses between the slow and the fast system clock. It moves to the fast clock only on a cycle in which the fast oscillator reports itself stable. It returns to the slow clock as soon as the fast clock is no longer requested.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode is running on the slow clock: `hs_sel_o`=0, `pdf_o`=0, `to_o`=0, `wdt_cnt_o`=0, `core_stall_o`=0, `sys_clk_en_o`=1 and `tb_clk_en_o`=1.
- R2: A halt strobe while running, with `idle_en_i`=0 and `wdt_en_i`=1, enters sleep one edge later. In sleep `sys_clk_en_o`=0, `tb_clk_en_o`=0, `sub_clk_en_o`=1 and `core_stall_o`=1, and the watchdog keeps counting.
- R3: A halt strobe with `idle_en_i`=0 and `wdt_en_i`=0 is ignored. The core keeps running, and `pdf_o`, `to_o` and `wdt_cnt_o` are unchanged by it.
- R4: A halt strobe while running, with `idle_en_i`=1 and `fsys_on_i`=0, enters idle-0. In idle-0 `sys_clk_en_o`=0, `tb_clk_en_o`=1, `sub_clk_en_o`=1 and `core_stall_o`=1.
- R5: A halt strobe while running, with `idle_en_i`=1 and `fsys_on_i`=1, enters idle-1. In idle-1 all three clock enables are 1 and `core_stall_o`=1.
- R6: At the edge that accepts a halt, `wdt_cnt_o` becomes 0, `pdf_o` becomes 1 and `to_o` becomes 0. This takes priority over a watchdog wrap or a `pdf_clr_i` in the same cycle.
- R7: `wake_i` in any halted mode returns the core to running at the next edge, with the clocks re-enabled, the stall released and `pdf_o` still 1. A halt strobe in a halted mode is ignored, and `wake_i` while running has no effect.
- R8: `pdf_clr_i` while no halt is accepted clears `pdf_o` at the next edge. No other event clears `pdf_o` except reset.
- R9: With `wdt_en_i`=1 the watchdog counter increments by one every cycle. At 2^WDT_W-1 it wraps to 0 and sets `to_o`. With `wdt_en_i`=0 it holds. While running, `sub_clk_en_o` equals `wdt_en_i`.
- R10: The fast clock is requested when `hi_sel_i`=1, or when `hi_sel_i`=0 and `clk_div_i` is 2 to 7. If it is not requested while running (`hi_sel_i`=0 and `clk_div_i` 0 or 1), `hs_sel_o` is 0 after the next edge.
- R11: While running, `hs_sel_o` goes from 0 to 1 only at an edge where the fast clock is requested and `hs_ready_i`=1. Once at 1, it stays at 1 while the request holds, whatever `hs_ready_i` does.
- R12: `hs_sel_o` does not change while the core is in a halted mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Single-cycle halt request from the core |
| wake_i | input | 1 | Wake-up event |
| idle_en_i | input | 1 | 1 selects an idle mode on halt, 0 selects sleep |
| fsys_on_i | input | 1 | In idle, 1 keeps the system clock running |
| wdt_en_i | input | 1 | Watchdog enable |
| pdf_clr_i | input | 1 | Clears the power-down flag |
| hi_sel_i | input | 1 | Direct request for the fast clock |
| clk_div_i | input | 3 | Clock divider select; 2 to 7 also request the fast clock |
| hs_ready_i | input | 1 | Fast oscillator stable |
| sys_clk_en_o | output | 1 | System clock enable |
| tb_clk_en_o | output | 1 | Time-base clock enable |
| sub_clk_en_o | output | 1 | Sub-clock enable |
| hs_sel_o | output | 1 | 1 when the system runs on the fast clock |
| core_stall_o | output | 1 | Holds instruction execution |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |
| wdt_cnt_o | output | WDT_W | Watchdog counter value |

## Verification
Every flag, the counter, the mode and `hs_sel_o` are registered and show the effect of an input one edge after that input is sampled. The clock enables and the stall follow the registered mode with no further delay. The only same-cycle path is `sub_clk_en_o` while running, which follows `wdt_en_i`. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge from the same sampled inputs. It compares every output three quarters of a period after each rising edge, so each result is checked in the exact cycle it is due.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_IDLE0 = 2'd2,
        MODE_IDLE1 = 2'd3
    } pwr_mode_e;
endpackage

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
    import pcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_i,
    input  logic      wake_i,
    input  logic      idle_en_i,
    input  logic      fsys_on_i,
    input  logic      wdt_en_i,
    input  logic      pdf_clr_i,
    input  logic      wdt_ovf_i,
    output pwr_mode_e mode_o,
    output logic      enter_o,
    output logic      pdf_o,
    output logic      to_o
);
    typedef struct packed {
        pwr_mode_e mode;
        logic      pdf;
        logic      to;
    } fsm_t;

    fsm_t s_d, s_q;
    logic enter_d;

    always_comb begin
        s_d     = s_q;
        enter_d = 1'b0;
        if (s_q.mode == MODE_RUN) begin
            // sleep needs a live watchdog to ever wake by time-out
            if (halt_i && (idle_en_i || wdt_en_i)) begin
                enter_d = 1'b1;
                if (!idle_en_i)
                    s_d.mode = MODE_SLEEP;
                else if (fsys_on_i)
                    s_d.mode = MODE_IDLE1;
                else
                    s_d.mode = MODE_IDLE0;
            end
        end else if (wake_i) begin
            s_d.mode = MODE_RUN;
        end
        if (enter_d) begin
            s_d.pdf = 1'b1;
            s_d.to  = 1'b0;
        end else begin
            if (pdf_clr_i) s_d.pdf = 1'b0;
            if (wdt_ovf_i) s_d.to  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MODE_RUN;
            s_q.pdf  <= 1'b0;
            s_q.to   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o  = s_q.mode;
    assign enter_o = enter_d;
    assign pdf_o   = s_q.pdf;
    assign to_o    = s_q.to;

    assert_no_sleep_without_wdt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && halt_i && !idle_en_i && !wdt_en_i) |=> (mode_o == MODE_RUN));
    assert_entry_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |=> (pdf_o && !to_o && mode_o != MODE_RUN));
    assert_wake_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_RUN && wake_i) |=> (mode_o == MODE_RUN));
    assert_halted_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_RUN && !wake_i) |=> $stable(mode_o));
    assert_pdf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pdf_o && !pdf_clr_i) |=> pdf_o);
endmodule

// File: rtl/pcc_wdt.sv
module pcc_wdt #(
    parameter int WDT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    output logic [WDT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [WDT_W-1:0] CNT_MAX = {WDT_W{1'b1}};

    typedef struct packed {
        logic [WDT_W-1:0] cnt;
    } wdt_t;

    wdt_t w_d, w_q;
    logic ovf_d;

    always_comb begin
        w_d   = w_q;
        ovf_d = 1'b0;
        if (clr_i) begin
            w_d.cnt = '0;
        end else if (en_i) begin
            if (w_q.cnt == CNT_MAX) begin
                w_d.cnt = '0;
                ovf_d   = 1'b1;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q.cnt <= '0;
        else        w_q     <= w_d;
    end

    assign cnt_o = w_q.cnt;
    assign ovf_o = ovf_d;

    assert_clear_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_o));
    assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o == '0));
endmodule

// File: rtl/pcc_clk_sel.sv
module pcc_clk_sel #(
    parameter int DIV_W    = 3,
    parameter int FAST_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hi_sel_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic             hs_ready_i,
    output logic             hs_sel_o
);
    localparam logic [DIV_W-1:0] DIV_FAST = DIV_W'(FAST_MIN);

    typedef struct packed {
        logic hs;
    } sel_t;

    sel_t c_d, c_q;
    logic want_fast;

    always_comb begin
        want_fast = hi_sel_i || (clk_div_i >= DIV_FAST);
        c_d       = c_q;
        if (run_i) begin
            if (!want_fast)
                c_d.hs = 1'b0;
            else if (hs_ready_i)
                c_d.hs = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q.hs <= 1'b0;
        else        c_q    <= c_d;
    end

    assign hs_sel_o = c_q.hs;

    assert_slow_when_unrequested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !hi_sel_i && clk_div_i < DIV_FAST) |=> !hs_sel_o);
    assert_switch_waits_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_sel_o && !hs_ready_i) |=> !hs_sel_o);
    assert_frozen_in_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(hs_sel_o));
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int WDT_W    = 8,
    parameter int DIV_W    = 3,
    parameter int FAST_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             wake_i,
    input  logic             idle_en_i,
    input  logic             fsys_on_i,
    input  logic             wdt_en_i,
    input  logic             pdf_clr_i,
    input  logic             hi_sel_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic             hs_ready_i,
    output logic             sys_clk_en_o,
    output logic             tb_clk_en_o,
    output logic             sub_clk_en_o,
    output logic             hs_sel_o,
    output logic             core_stall_o,
    output logic             pdf_o,
    output logic             to_o,
    output logic [WDT_W-1:0] wdt_cnt_o
);
    pwr_mode_e mode;
    logic      enter;
    logic      wdt_ovf;
    logic      running;

    pcc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_i),
        .wake_i    (wake_i),
        .idle_en_i (idle_en_i),
        .fsys_on_i (fsys_on_i),
        .wdt_en_i  (wdt_en_i),
        .pdf_clr_i (pdf_clr_i),
        .wdt_ovf_i (wdt_ovf),
        .mode_o    (mode),
        .enter_o   (enter),
        .pdf_o     (pdf_o),
        .to_o      (to_o)
    );

    pcc_wdt #(.WDT_W(WDT_W)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (wdt_en_i),
        .clr_i (enter),
        .cnt_o (wdt_cnt_o),
        .ovf_o (wdt_ovf)
    );

    assign running = (mode == MODE_RUN);

    pcc_clk_sel #(.DIV_W(DIV_W), .FAST_MIN(FAST_MIN)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (running),
        .hi_sel_i   (hi_sel_i),
        .clk_div_i  (clk_div_i),
        .hs_ready_i (hs_ready_i),
        .hs_sel_o   (hs_sel_o)
    );

    always_comb begin
        sys_clk_en_o = (mode == MODE_RUN) || (mode == MODE_IDLE1);
        tb_clk_en_o  = (mode != MODE_SLEEP);
        sub_clk_en_o = !running || wdt_en_i;
        core_stall_o = !running;
    end

    assert_sys_off_means_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en_o |-> core_stall_o);
    assert_tb_off_only_in_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_clk_en_o |-> (!sys_clk_en_o && sub_clk_en_o));
    assert_halt_clears_wdt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall_o && halt_i && (idle_en_i || wdt_en_i)) |=> (core_stall_o && wdt_cnt_o == '0));
    assert_idle1_keeps_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall_o && halt_i && idle_en_i && fsys_on_i) |=> (sys_clk_en_o && tb_clk_en_o));
endmodule

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDT_W      = 8;
    localparam int CNT_MAX    = (1 << WDT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_i = 0, wake_i = 0, idle_en_i = 0, fsys_on_i = 0, wdt_en_i = 0;
    logic pdf_clr_i = 0, hi_sel_i = 0, hs_ready_i = 0;
    logic [2:0] clk_div_i = 3'd0;
    logic sys_clk_en_o, tb_clk_en_o, sub_clk_en_o, hs_sel_o, core_stall_o, pdf_o, to_o;
    logic [WDT_W-1:0] wdt_cnt_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    // behavioural reference: 0 run, 1 sleep, 2 idle0, 3 idle1
    int m_mode = 0;
    int m_cnt  = 0;
    bit m_pdf  = 0, m_to = 0, m_hs = 0;

    pwr_clk_ctrl #(.WDT_W(WDT_W)) uut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wake_i(wake_i),
        .idle_en_i(idle_en_i), .fsys_on_i(fsys_on_i), .wdt_en_i(wdt_en_i),
        .pdf_clr_i(pdf_clr_i), .hi_sel_i(hi_sel_i), .clk_div_i(clk_div_i),
        .hs_ready_i(hs_ready_i), .sys_clk_en_o(sys_clk_en_o), .tb_clk_en_o(tb_clk_en_o),
        .sub_clk_en_o(sub_clk_en_o), .hs_sel_o(hs_sel_o), .core_stall_o(core_stall_o),
        .pdf_o(pdf_o), .to_o(to_o), .wdt_cnt_o(wdt_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_pdf = 0; m_to = 0; m_hs = 0;
        end else begin
            bit enter, wrap, want;
            enter = (m_mode == 0) && halt_i && (idle_en_i || wdt_en_i);
            want  = hi_sel_i || (clk_div_i >= 2);
            if (m_mode == 0) m_hs = want ? (m_hs || hs_ready_i) : 1'b0;
            wrap = 0;
            if (enter) m_cnt = 0;
            else if (wdt_en_i) begin
                if (m_cnt == CNT_MAX) begin m_cnt = 0; wrap = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (enter) begin m_pdf = 1; m_to = 0; end
            else begin
                if (pdf_clr_i) m_pdf = 0;
                if (wrap) m_to = 1;
            end
            if (enter) m_mode = !idle_en_i ? 1 : (fsys_on_i ? 3 : 2);
            else if (m_mode != 0 && wake_i) m_mode = 0;
        end
    end

    always begin
        @(posedge clk);
        #(CLK_PERIOD*3/4);
        if (rst_n) begin
            chk("sys_clk_en", sys_clk_en_o, (m_mode == 0 || m_mode == 3));
            chk("tb_clk_en",  tb_clk_en_o,  (m_mode != 1));
            chk("sub_clk_en", sub_clk_en_o, (m_mode != 0) || wdt_en_i);
            chk("core_stall", core_stall_o, (m_mode != 0));
            chk("hs_sel",     hs_sel_o,     m_hs);
            chk("pdf",        pdf_o,        m_pdf);
            chk("to",         to_o,         m_to);
            chk("wdt_cnt",    wdt_cnt_o,    m_cnt);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_halt();
        @(negedge clk); halt_i = 1;
        @(negedge clk); halt_i = 0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_i = 1;
        @(negedge clk); wake_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        // R1 reset values, explicit
        @(posedge clk); #(CLK_PERIOD/4);
        cur_req = "R1";
        chk("reset hs_sel", hs_sel_o, 0);
        chk("reset pdf", pdf_o, 0);
        chk("reset to", to_o, 0);
        chk("reset stall", core_stall_o, 0);
        chk("reset sys_clk_en", sys_clk_en_o, 1);

        // R11 fast request waits for ready, then holds
        cur_req = "R11";
        @(negedge clk); hi_sel_i = 1; hs_ready_i = 0;
        cycles(5);
        hs_ready_i = 1; cycles(1);
        hs_ready_i = 0; cycles(4);
        // R10 divider-only request and its release
        cur_req = "R10";
        hi_sel_i = 0; clk_div_i = 3'd1; cycles(3);
        clk_div_i = 3'd0; cycles(2);
        clk_div_i = 3'd2; cycles(3);
        hs_ready_i = 1; cycles(2);
        clk_div_i = 3'd7; hs_ready_i = 0; cycles(2);

        // R9 watchdog count, wrap and time-out
        cur_req = "R9";
        wdt_en_i = 1; cycles(CNT_MAX + 10);
        wdt_en_i = 0; cycles(5);
        wdt_en_i = 1;

        // R7 wake while running has no effect
        cur_req = "R7";
        pulse_wake(); cycles(2);

        // R2 and R6 sleep entry, counting while asleep
        cur_req = "R2";
        idle_en_i = 0; pulse_halt();
        cur_req = "R12";
        clk_div_i = 3'd0; hs_ready_i = 1; cycles(5);
        cur_req = "R6";
        cycles(CNT_MAX + 5);
        cur_req = "R7";
        pulse_halt(); cycles(3);
        pulse_wake(); cycles(3);

        // R8 software clear of power-down flag
        cur_req = "R8";
        @(negedge clk); pdf_clr_i = 1;
        @(negedge clk); pdf_clr_i = 0;
        cycles(2);

        // R3 sleep refused with watchdog off
        cur_req = "R3";
        wdt_en_i = 0; pulse_halt(); cycles(4);

        // R4 idle-0
        cur_req = "R4";
        idle_en_i = 1; fsys_on_i = 0; pulse_halt(); cycles(6);
        pulse_wake(); cycles(2);

        // R5 idle-1, clear and halt in same cycle (R6 priority)
        cur_req = "R5";
        fsys_on_i = 1; wdt_en_i = 1;
        @(negedge clk); pdf_clr_i = 1;
        @(negedge clk); pdf_clr_i = 0;
        @(negedge clk); halt_i = 1; pdf_clr_i = 1;
        @(negedge clk); halt_i = 0; pdf_clr_i = 0;
        hi_sel_i = 1; cycles(6);
        cur_req = "R7";
        pulse_wake(); cycles(4);

        // R6 halt on the wrap cycle: entry beats time-out
        cur_req = "R6";
        while (wdt_cnt_o != WDT_W'(CNT_MAX)) @(negedge clk);
        halt_i = 1; @(negedge clk); halt_i = 0;
        cycles(3);
        pulse_wake(); cycles(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule